// File: doc/BRIEF.md
# DAC Command Decoder and Power Controller

This block sits behind the serial receiver of a 12-bit voltage-output converter. Each accepted 16-bit command word is decoded into loads of a double-buffered code path (a staging register and the register that drives the converter), or into an escape action. The escape actions set a general-purpose logic output, select the timing mode of the serial echo output, or request power-down. The block also owns the asynchronous control pins: a power-down request, a power-down permit that blocks every power-down request while low, an active-low clear, and a strap that selects the value used by reset and clear.

The outputs are the 12-bit code for the converter core, an output-enable (low means the analog output floats), the user logic output and the echo-mode bit. A wake flag stays high for a programmable number of cycles after the block leaves power-down, so that downstream logic can wait for the output to settle. Power-down keeps all stored state, so the previous output level comes back on wake-up unless new data was loaded.

Word layout, MSB first: bits [15:14] are the control pair, bits [13:2] the data field, and bits [1:0] are spare. In an escape word (control pair 11), bits [13:10] select the action.

Top module: `dac_cmd_ctrl`

## Requirements
- R1: A valid word with control pair 00 writes the data field [13:2] into the staging register, and `dac_code` does not change.
- R2: A valid word with control pair 01 copies the staging register into the code register, so `dac_code` shows the staged value one cycle later.
- R3: A valid word with control pair 10 writes the data field into both registers, so `dac_code` shows it one cycle later.
- R4: Escape selector [13:10] = 101x drives `user_out` high, and 100x drives it low.
- R5: Escape selector 110x sets `dout_alt_mode` to 1, and 111x sets it to 0. Selector 00xx changes no output. Spare bits [1:0] never affect any register.
- R6: Power-down (`out_en` = 0) is entered on escape selector 01xx or on a rising edge of the synchronized `shdn_req`, but only while the synchronized `pd_allow` is high. While `pd_allow` is low, both requests are ignored.
- R7: Power-down ends only on a falling edge of the synchronized `pd_allow` or on a valid control-pair 01 or 10 word. A falling `shdn_req` does not end it. During power-down, `dac_code` holds its value and the staging register accepts loads.
- R8: While the synchronized `clr_n` is low, the code register is forced to 0 (`rs_mid` = 0) or 0x800 (`rs_mid` = 1) and `user_out` to 0. Any command in such a cycle is dropped, including staging-register loads. `dout_alt_mode` is not touched.
- R9: After reset, `dac_code` is 0 or 0x800 as selected by `rs_mid`, `out_en` is 1, `user_out` is 0, `dout_alt_mode` is 0 and `wake_busy` is 0.
- R10: `user_out` and `dout_alt_mode` keep their levels when power-down is entered.
- R11: `wake_busy` is high for exactly WAKE_CYCLES cycles, starting in the cycle in which `out_en` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word is valid this cycle |
| cmd_word | input | 16 | Command word |
| shdn_req | input | 1 | Asynchronous power-down request; acts on its rising edge |
| pd_allow | input | 1 | Asynchronous power-down permit; its falling edge wakes the block |
| clr_n | input | 1 | Asynchronous active-low clear |
| rs_mid | input | 1 | Static strap: 1 selects midscale for reset and clear, 0 selects zero |
| dac_code | output | 12 | Code for the converter core |
| out_en | output | 1 | 1 drives the analog output; 0 floats it |
| user_out | output | 1 | User logic output |
| dout_alt_mode | output | 1 | Echo-output timing mode (0 is the default) |
| wake_busy | output | 1 | Settling interval after leaving power-down |

## Verification
A command accepted at a clock edge shows on every output right after that edge. The bench drives each word on a falling edge, removes it at the next falling edge, and samples there. Each pin change passes two synchronizer flops and one edge-detect or state register, so it shows after the third rising edge. The bench waits five cycles before it samples. The settling flag is counted at falling edges from the first cycle in which `out_en` is high again, so the count has to equal WAKE_CYCLES exactly.

// File: rtl/dac_cmd_pkg.sv
`timescale 1ns/1ps
package dac_cmd_pkg;
    parameter int DATA_W = 12;
    parameter int CTRL_W = 2;
    parameter int SUB_W  = 2;
    parameter int SEL_W  = 4;
    localparam int WORD_W = CTRL_W + DATA_W + SUB_W;

    typedef enum logic [3:0] {
        OP_NONE, OP_LOAD_IN, OP_XFER, OP_LOAD_BOTH,
        OP_SHDN, OP_UPO_LO, OP_UPO_HI, OP_MODE_ALT, OP_MODE_DEF
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [DATA_W-1:0] data;
    } dec_t;

    typedef struct packed {
        logic [DATA_W-1:0] stage;
        logic [DATA_W-1:0] code;
        logic              upo;
        logic              alt_mode;
    } regs_t;
endpackage

// File: rtl/dac_pin_sync.sv
`timescale 1ns/1ps
module dac_pin_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[g] <= RST_VAL;
            else if (g == 0) chain_q[g] <= async_in;
            else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
        end
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/dac_cmd_decode.sv
`timescale 1ns/1ps
module dac_cmd_decode
    import dac_cmd_pkg::*;
(
    input  logic              valid,
    input  logic [WORD_W-1:0] word,
    output dec_t              dec
);
    logic [CTRL_W-1:0] ctrl;
    logic [SEL_W-1:0]  sel;
    logic [SUB_W-1:0]  unused_sub;

    assign ctrl       = word[WORD_W-1 -: CTRL_W];
    assign sel        = word[WORD_W-CTRL_W-1 -: SEL_W];
    assign unused_sub = word[SUB_W-1:0];

    always_comb begin
        dec.data = word[SUB_W +: DATA_W];
        dec.op   = OP_NONE;
        if (valid) begin
            unique case (ctrl)
                2'b00: dec.op = OP_LOAD_IN;
                2'b01: dec.op = OP_XFER;
                2'b10: dec.op = OP_LOAD_BOTH;
                default: begin
                    casez (sel)
                        4'b00??: dec.op = OP_NONE;
                        4'b01??: dec.op = OP_SHDN;
                        4'b100?: dec.op = OP_UPO_LO;
                        4'b101?: dec.op = OP_UPO_HI;
                        4'b110?: dec.op = OP_MODE_ALT;
                        default: dec.op = OP_MODE_DEF;
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/dac_pwr_ctrl.sv
`timescale 1ns/1ps
module dac_pwr_ctrl #(
    parameter int WAKE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic allow_s,
    input  logic shdn_s,
    input  logic sw_shdn,
    input  logic dac_load,
    output logic pdl_fall,
    output logic powered_down,
    output logic wake_busy
);
    localparam int CNT_W = $clog2(WAKE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WAKE_CYCLES);

    typedef struct packed {
        logic             sd;
        logic             allow_prev;
        logic             shdn_prev;
        logic [CNT_W-1:0] cnt;
    } pwr_t;

    pwr_t st_d, st_q;
    logic shdn_rise, enter, leave;

    assign pdl_fall  = st_q.allow_prev && !allow_s;
    assign shdn_rise = shdn_s && !st_q.shdn_prev;
    assign enter     = !st_q.sd && allow_s && (shdn_rise || sw_shdn);
    assign leave     = st_q.sd && (pdl_fall || dac_load);

    always_comb begin
        st_d            = st_q;
        st_d.allow_prev = allow_s;
        st_d.shdn_prev  = shdn_s;
        if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
        if (leave) begin
            st_d.sd  = 1'b0;
            st_d.cnt = CNT_LOAD;
        end else if (enter) begin
            st_d.sd = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign powered_down = st_q.sd;
    assign wake_busy    = st_q.cnt != '0;
endmodule

// File: rtl/dac_cmd_ctrl.sv
`timescale 1ns/1ps
module dac_cmd_ctrl
    import dac_cmd_pkg::*;
#(
    parameter int WAKE_CYCLES = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic              shdn_req,
    input  logic              pd_allow,
    input  logic              clr_n,
    input  logic              rs_mid,
    output logic [DATA_W-1:0] dac_code,
    output logic              out_en,
    output logic              user_out,
    output logic              dout_alt_mode,
    output logic              wake_busy
);
    localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};
    localparam int PIN_N = 3;
    // Synchronizer reset levels: clear inactive (1), permit low, request low.
    localparam logic [PIN_N-1:0] PIN_RST = 3'b100;

    logic [PIN_N-1:0] pins_s;
    logic clr_act, lock_s, shdn_s;
    logic pdl_fall, dac_load, sw_shdn, powered_down;
    logic [DATA_W-1:0] rst_code;
    dec_t dec;
    regs_t r_d, r_q;

    dac_pin_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({clr_n, pd_allow, shdn_req}),
        .sync_out (pins_s)
    );

    assign clr_act = !pins_s[2];
    assign lock_s  = pins_s[1];
    assign shdn_s  = pins_s[0];

    dac_cmd_decode u_dec (
        .valid (cmd_valid),
        .word  (cmd_word),
        .dec   (dec)
    );

    assign dac_load = !clr_act && (dec.op == OP_XFER || dec.op == OP_LOAD_BOTH);
    assign sw_shdn  = !clr_act && (dec.op == OP_SHDN);

    dac_pwr_ctrl #(.WAKE_CYCLES(WAKE_CYCLES)) u_pwr (
        .clk          (clk),
        .rst_n        (rst_n),
        .allow_s      (lock_s),
        .shdn_s       (shdn_s),
        .sw_shdn      (sw_shdn),
        .dac_load     (dac_load),
        .pdl_fall     (pdl_fall),
        .powered_down (powered_down),
        .wake_busy    (wake_busy)
    );

    assign rst_code = rs_mid ? MID_CODE : '0;

    always_comb begin
        r_d = r_q;
        if (clr_act) begin
            r_d.code = rst_code;
            r_d.upo  = 1'b0;
        end else begin
            unique case (dec.op)
                OP_LOAD_IN:   r_d.stage = dec.data;
                OP_XFER:      r_d.code  = r_q.stage;
                OP_LOAD_BOTH: begin
                    r_d.stage = dec.data;
                    r_d.code  = dec.data;
                end
                OP_UPO_LO:    r_d.upo      = 1'b0;
                OP_UPO_HI:    r_d.upo      = 1'b1;
                OP_MODE_ALT:  r_d.alt_mode = 1'b1;
                OP_MODE_DEF:  r_d.alt_mode = 1'b0;
                default:      ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.stage    <= '0;
            r_q.code     <= rst_code;
            r_q.upo      <= 1'b0;
            r_q.alt_mode <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign dac_code      = r_q.code;
    assign user_out      = r_q.upo;
    assign dout_alt_mode = r_q.alt_mode;
    assign out_en        = !powered_down;
endmodule

// File: rtl/dac_cmd_ctrl_chk.sv
`timescale 1ns/1ps
module dac_cmd_ctrl_chk #(
    parameter int DATA_W = 12,
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [WORD_W-1:0] cmd_word,
    input logic              rs_mid,
    input logic [DATA_W-1:0] dac_code,
    input logic              out_en,
    input logic              user_out,
    input logic              wake_busy,
    input logic              clr_act,
    input logic              lock_s,
    input logic              pdl_fall,
    input logic              dac_load
);
    localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

    AST_STAGE_ONLY_KEEPS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_word[WORD_W-1 -: 2] == 2'b00 && !clr_act) |=> $stable(dac_code)); // R1

    AST_BOTH_LOAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_word[WORD_W-1 -: 2] == 2'b10 && !clr_act)
        |=> dac_code == $past(cmd_word[2 +: DATA_W])); // R3

    AST_SD_NEEDS_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_en) |-> $past(lock_s)); // R6

    AST_WAKE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_en) |-> $past(pdl_fall || dac_load)); // R7

    AST_SD_HOLDS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_en && $past(!out_en) && !$past(clr_act)) |-> $stable(dac_code)); // R7

    AST_CLR_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_act |=> (!user_out && dac_code == ($past(rs_mid) ? MID : '0))); // R8

    AST_WAKE_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_en) |-> wake_busy); // R11
endmodule

bind dac_cmd_ctrl dac_cmd_ctrl_chk #(.DATA_W(dac_cmd_pkg::DATA_W), .WORD_W(dac_cmd_pkg::WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .rs_mid    (rs_mid),
    .dac_code  (dac_code),
    .out_en    (out_en),
    .user_out  (user_out),
    .wake_busy (wake_busy),
    .clr_act   (clr_act),
    .lock_s    (lock_s),
    .pdl_fall  (pdl_fall),
    .dac_load  (dac_load)
);

// File: tb/dac_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module dac_cmd_ctrl_tb;
    localparam int WAKE = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_word = '0;
    logic        shdn_req = 1'b0;
    logic        pd_allow = 1'b1;
    logic        clr_n = 1'b1;
    logic        rs_mid = 1'b0;
    logic [11:0] dac_code;
    logic        out_en, user_out, dout_alt_mode, wake_busy;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dac_cmd_ctrl #(.WAKE_CYCLES(WAKE)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .shdn_req(shdn_req), .pd_allow(pd_allow), .clr_n(clr_n), .rs_mid(rs_mid),
        .dac_code(dac_code), .out_en(out_en), .user_out(user_out),
        .dout_alt_mode(dout_alt_mode), .wake_busy(wake_busy)
    );

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
        end
    endtask

    function automatic logic [15:0] word(input logic [1:0] c, input logic [11:0] d,
                                         input logic [1:0] s);
        return {c, d, s};
    endfunction

    function automatic logic [15:0] esc(input logic [3:0] sel);
        return {2'b11, sel, 8'h00, 2'b00};
    endfunction

    task automatic send(input logic [15:0] w);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = w;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_word  = '0;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic do_reset(input logic rs);
        @(negedge clk);
        rst_n = 1'b0; rs_mid = rs; shdn_req = 1'b0; pd_allow = 1'b1; clr_n = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        chk("R9 code zero", dac_code, 0);
        chk("R9 out_en", out_en, 1);
        chk("R9 user_out", user_out, 0);
        chk("R9 mode", dout_alt_mode, 0);
        chk("R9 wake_busy", wake_busy, 0);
    endtask

    task automatic t_loads();
        send(word(2'b00, 12'hABC, 2'b00));
        chk("R1 stage only", dac_code, 0);
        send(word(2'b01, 12'h000, 2'b00));
        chk("R2 transfer", dac_code, 'hABC);
        send(word(2'b10, 12'h123, 2'b00));
        chk("R3 load both", dac_code, 'h123);
    endtask

    task automatic t_escape();
        send(esc(4'b1010));
        chk("R4 upo high", user_out, 1);
        send(esc(4'b1000));
        chk("R4 upo low", user_out, 0);
        send(esc(4'b1100));
        chk("R5 mode alt", dout_alt_mode, 1);
        send(esc(4'b1110));
        chk("R5 mode default", dout_alt_mode, 0);
        send({2'b11, 4'b0011, 8'hFF, 2'b11});
        chk("R5 nop code", dac_code, 'h123);
        chk("R5 nop upo", user_out, 0);
        chk("R5 nop mode", dout_alt_mode, 0);
        send(word(2'b00, 12'h3C5, 2'b11));
        send(word(2'b01, 12'h000, 2'b10));
        chk("R5 spare bits", dac_code, 'h3C5);
    endtask

    task automatic t_sw_shutdown();
        int n;
        send(esc(4'b1011));
        send(esc(4'b1101));
        send(esc(4'b0100));
        chk("R6 sw shutdown", out_en, 0);
        chk("R10 upo kept", user_out, 1);
        chk("R10 mode kept", dout_alt_mode, 1);
        send(word(2'b00, 12'h555, 2'b00));
        chk("R7 stays down on stage load", out_en, 0);
        chk("R7 code held", dac_code, 'h3C5);
        send(word(2'b01, 12'h000, 2'b00));
        chk("R7 wake by transfer", out_en, 1);
        chk("R7 staged value", dac_code, 'h555);
        n = 0;
        while (wake_busy && n < 100) begin
            n++;
            @(negedge clk);
        end
        chk("R11 wake length", n, WAKE);
    endtask

    task automatic t_pin_shutdown();
        shdn_req = 1'b1; settle();
        chk("R6 pin shutdown", out_en, 0);
        shdn_req = 1'b0; settle();
        chk("R7 request low no wake", out_en, 0);
        chk("R10 upo kept pin", user_out, 1);
        pd_allow = 1'b0; settle();
        chk("R7 permit fall wakes", out_en, 1);
        chk("R7 code restored", dac_code, 'h555);
    endtask

    task automatic t_lockout();
        shdn_req = 1'b1; settle();
        chk("R6 pin ignored locked", out_en, 1);
        send(esc(4'b0110));
        chk("R6 sw ignored locked", out_en, 1);
        shdn_req = 1'b0; pd_allow = 1'b1; settle();
        chk("R6 permit rise no effect", out_en, 1);
    endtask

    task automatic t_clear();
        rs_mid = 1'b0; clr_n = 1'b0; settle();
        chk("R8 clear zero", dac_code, 0);
        chk("R8 clear upo", user_out, 0);
        chk("R8 mode untouched", dout_alt_mode, 1);
        send(word(2'b10, 12'h777, 2'b00));
        chk("R8 command dropped", dac_code, 0);
        clr_n = 1'b1; settle();
        send(word(2'b01, 12'h000, 2'b00));
        chk("R8 stage untouched", dac_code, 'h555);
        rs_mid = 1'b1; clr_n = 1'b0; settle();
        chk("R8 clear mid", dac_code, 'h800);
        clr_n = 1'b1; settle();
    endtask

    task automatic t_reset_mid();
        do_reset(1'b1);
        chk("R9 code mid", dac_code, 'h800);
        chk("R9 upo after mid", user_out, 0);
    endtask

    initial begin
        t_reset();
        t_loads();
        t_escape();
        t_sw_shutdown();
        t_pin_shutdown();
        t_lockout();
        t_clear();
        t_reset_mid();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule